// File: doc/BRIEF.md
# Dual-Channel Serial Clock-Synthesizer Word Receiver

This block takes in the configuration words for two clock-synthesis channels. A single data line is shared by both channels, and each channel has its own serial clock. The serial clocks, the data line and the two reference-select lines are brought into the system clock domain through a synchronizer. A rising edge on a channel's serial clock is found by comparing successive synchronized samples, and each such edge shifts one data bit into that channel's register, most significant bit first.

When a channel has taken in its 22nd bit, the finished word is copied into that channel's holding register and a valid strobe is raised for one cycle. The held word is split into five fields: a range index, a feedback divider, a reserved bit, a post-divider select and a reference divider. The two divider fields are presented as their true values, with the offset each one carries already added.

A channel may only be loaded while its reference-select line is low, which means the output is running from the reference clock. If a serial clock edge arrives while that line is high, the bit is thrown away and a sticky error flag is set. A rising edge on reference-select drops any partly shifted word.

Top module: `pll_word_rx`

## Requirements
- R1: After reset, every valid strobe and error flag is 0, and each channel's fields show an all-zero word: index 0, P 3, reserved 0, mux 0, Q 2.
- R2: A channel's word is exactly 22 bits, taken on 22 rising edges of its serial clock with the first bit as bit 21. The valid strobe rises only after the 22nd accepted edge.
- R3: In the 22-bit word, bits 21:18 are the index, bits 17:11 the P field, bit 10 the reserved bit, bits 9:7 the mux select and bits 6:0 the Q field.
- R4: The 8-bit P output is the P field plus 3, and the 8-bit Q output is the Q field plus 2.
- R5: The channels share the data line but count independently. Edges on one channel's serial clock do not change the other channel's count, held word or error flag.
- R6: A serial clock rising edge that arrives while the channel's reference-select line is high (programmed output selected) sets that channel's error flag and shifts no bit.
- R7: A rising edge on a channel's reference-select line discards any partly received word, so the next word must supply all 22 bits again.
- R8: A channel's field outputs change only in the cycle its valid strobe is high, and hold steady across partial words and across loads on the other channel.
- R9: The valid strobe for a completed word is high for exactly one system clock cycle.
- R10: Once set, the error flag stays set until reset, even while further words load correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data shared by both channels |
| sclk_i | input | NUM_CH | Serial clock per channel, asynchronous |
| refsel_i | input | NUM_CH | Per channel: 0 = reference selected (loading allowed), 1 = programmed output |
| valid_o | output | NUM_CH | One-cycle strobe per channel when a new word is held |
| idx_o | output | 4*NUM_CH | Range index per channel |
| p_o | output | 8*NUM_CH | True feedback divider per channel |
| rsv_o | output | NUM_CH | Reserved bit per channel |
| mux_o | output | 3*NUM_CH | Post-divider select per channel |
| q_o | output | 8*NUM_CH | True reference divider per channel |
| err_o | output | NUM_CH | Sticky protocol error per channel |

## Verification
The embedded properties are checked on every cycle. They cover: the bit counter never passing the word length, the valid strobe lasting one cycle, the held word staying still outside a strobe, the error flag being set by an edge that arrives while reference-select is high and then staying set, and a rising reference-select clearing the counter. The bench scenarios cover what those properties cannot: MSB-first bit order, the field positions and the offset arithmetic checked against words computed independently. They also cover interleaving the two channels over the shared data line, a partial word being dropped, and a bit rejected while selection was wrong not being counted toward the next word.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;
    localparam int IDX_W   = 4;
    localparam int PF_W    = 7;
    localparam int MUX_W   = 3;
    localparam int QF_W    = 7;
    localparam int WORD_W  = IDX_W + PF_W + 1 + MUX_W + QF_W;
    localparam int CNT_W   = $clog2(WORD_W + 1);
    localparam int PT_W    = PF_W + 1;
    localparam int QT_W    = QF_W + 1;
    localparam int P_OFS   = 3;
    localparam int Q_OFS   = 2;
    localparam int Q_LSB   = 0;
    localparam int MUX_LSB = Q_LSB + QF_W;
    localparam int RSV_POS = MUX_LSB + MUX_W;
    localparam int P_LSB   = RSV_POS + 1;
    localparam int IDX_LSB = P_LSB + PF_W;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [PT_W-1:0]  p;
        logic             rsv;
        logic [MUX_W-1:0] mux;
        logic [QT_W-1:0]  q;
    } cfg_t;
endpackage

// File: rtl/sync_cell.sv
module sync_cell #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/word_shifter.sv
module word_shifter
    import pllcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              data_s,
    input  logic              refsel_s,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              err_o
);
    typedef struct packed {
        logic              sclk_prev;
        logic              refsel_prev;
        logic [WORD_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] hold;
        logic              valid;
        logic              err;
    } st_t;

    st_t st_d, st_q;
    logic rise;
    logic refsel_up;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        st_d             = st_q;
        st_d.valid       = 1'b0;
        st_d.sclk_prev   = sclk_s;
        st_d.refsel_prev = refsel_s;
        rise             = sclk_s & ~st_q.sclk_prev;
        refsel_up        = refsel_s & ~st_q.refsel_prev;
        shifted          = {st_q.shift[WORD_W-2:0], data_s};
        if (refsel_up) begin
            st_d.cnt = '0;
        end
        if (rise) begin
            if (refsel_s) begin
                st_d.err = 1'b1;
            end else begin
                st_d.shift = shifted;
                if (st_q.cnt == CNT_W'(WORD_W - 1)) begin
                    st_d.hold  = shifted;
                    st_d.cnt   = '0;
                    st_d.valid = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o  = st_q.hold;
    assign valid_o = st_q.valid;
    assign err_o   = st_q.err;

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(WORD_W));
    p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_s && !st_q.sclk_prev && refsel_s) |=> st_q.err);
    p_refsel_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (refsel_s && !st_q.refsel_prev) |=> (st_q.cnt == '0));
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.valid |-> $stable(st_q.hold));
    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);
endmodule

// File: rtl/field_decode.sv
module field_decode
    import pllcfg_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output cfg_t              cfg_o
);
    always_comb begin
        cfg_o.idx = word_i[IDX_LSB +: IDX_W];
        cfg_o.p   = PT_W'(word_i[P_LSB +: PF_W]) + PT_W'(P_OFS);
        cfg_o.rsv = word_i[RSV_POS];
        cfg_o.mux = word_i[MUX_LSB +: MUX_W];
        cfg_o.q   = QT_W'(word_i[Q_LSB +: QF_W]) + QT_W'(Q_OFS);
    end
endmodule

// File: rtl/pll_word_rx.sv
module pll_word_rx
    import pllcfg_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sdata_i,
    input  logic [NUM_CH-1:0]       sclk_i,
    input  logic [NUM_CH-1:0]       refsel_i,
    output logic [NUM_CH-1:0]       valid_o,
    output logic [NUM_CH*IDX_W-1:0] idx_o,
    output logic [NUM_CH*PT_W-1:0]  p_o,
    output logic [NUM_CH-1:0]       rsv_o,
    output logic [NUM_CH*MUX_W-1:0] mux_o,
    output logic [NUM_CH*QT_W-1:0]  q_o,
    output logic [NUM_CH-1:0]       err_o
);
    localparam int SYNC_W = 1 + 2 * NUM_CH;

    logic [SYNC_W-1:0] raw_in, synced;
    logic              data_s;
    logic [NUM_CH-1:0] sclk_s, refsel_s;

    assign raw_in = {refsel_i, sclk_i, sdata_i};

    sync_cell #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (synced)
    );

    assign data_s   = synced[0];
    assign sclk_s   = synced[NUM_CH:1];
    assign refsel_s = synced[SYNC_W-1:NUM_CH+1];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [WORD_W-1:0] held;
        cfg_t              cfg;

        word_shifter u_shift (
            .clk      (clk),
            .rst_n    (rst_n),
            .sclk_s   (sclk_s[c]),
            .data_s   (data_s),
            .refsel_s (refsel_s[c]),
            .word_o   (held),
            .valid_o  (valid_o[c]),
            .err_o    (err_o[c])
        );

        field_decode u_dec (
            .word_i (held),
            .cfg_o  (cfg)
        );

        assign idx_o[c*IDX_W +: IDX_W] = cfg.idx;
        assign p_o[c*PT_W +: PT_W]     = cfg.p;
        assign rsv_o[c]                = cfg.rsv;
        assign mux_o[c*MUX_W +: MUX_W] = cfg.mux;
        assign q_o[c*QT_W +: QT_W]     = cfg.q;
    end
endmodule

// File: tb/pll_word_rx_test.sv
module pll_word_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sdata = 1'b0;
    logic [1:0] sclk = 2'b00;
    logic [1:0] refsel = 2'b00;
    logic [1:0]  valid_o, rsv_o, err_o;
    logic [7:0]  idx_o;
    logic [15:0] p_o, q_o;
    logic [5:0]  mux_o;

    int checks = 0;
    int fails  = 0;
    logic [21:0] expq [2][$];
    logic [1:0]  vprev = 2'b00;

    always #4 clk = ~clk;

    pll_word_rx uut (
        .clk(clk), .rst_n(rst_n), .sdata_i(sdata), .sclk_i(sclk),
        .refsel_i(refsel), .valid_o(valid_o), .idx_o(idx_o), .p_o(p_o),
        .rsv_o(rsv_o), .mux_o(mux_o), .q_o(q_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int fld(input int ch, input int sel);
        case (sel)
            0: return int'(idx_o[ch*4 +: 4]);
            1: return int'(p_o[ch*8 +: 8]);
            2: return int'(rsv_o[ch]);
            3: return int'(mux_o[ch*3 +: 3]);
            default: return int'(q_o[ch*8 +: 8]);
        endcase
    endfunction

    // monitor: compares each strobe against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            for (int ch = 0; ch < 2; ch++) begin
                if (valid_o[ch]) begin
                    check(!vprev[ch], "R9", "strobe longer than one cycle", 1, 0);
                    if (expq[ch].size() == 0) begin
                        check(1'b0, "R2", "unexpected strobe", 1, 0);
                    end else begin
                        logic [21:0] w;
                        w = expq[ch].pop_front();
                        check(fld(ch,0) == int'(w[21:18]), "R3", "index", fld(ch,0), int'(w[21:18]));
                        check(fld(ch,1) == int'(w[17:11]) + 3, "R4", "P true", fld(ch,1), int'(w[17:11]) + 3);
                        check(fld(ch,2) == int'(w[10]), "R3", "reserved", fld(ch,2), int'(w[10]));
                        check(fld(ch,3) == int'(w[9:7]), "R3", "mux", fld(ch,3), int'(w[9:7]));
                        check(fld(ch,4) == int'(w[6:0]) + 2, "R4", "Q true", fld(ch,4), int'(w[6:0]) + 2);
                    end
                end
                vprev[ch] = valid_o[ch];
            end
        end
    end

    task automatic send_bits(input int ch, input logic [21:0] w, input int hi, input int lo);
        for (int b = hi; b >= lo; b--) begin
            sdata = w[b];
            repeat (2) @(negedge clk);
            sclk[ch] = 1'b1;
            repeat (4) @(negedge clk);
            sclk[ch] = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic send_word(input int ch, input logic [21:0] w);
        expq[ch].push_back(w);
        send_bits(ch, w, 21, 0);
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_refsel(input int ch);
        refsel[ch] = 1'b1;
        repeat (8) @(negedge clk);
        refsel[ch] = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int snap [5];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(valid_o == 2'b00, "R1", "valid after reset", int'(valid_o), 0);
        check(err_o == 2'b00, "R1", "err after reset", int'(err_o), 0);
        for (int ch = 0; ch < 2; ch++) begin
            check(fld(ch,1) == 3 && fld(ch,4) == 2, "R1", "P/Q reset", fld(ch,1)*256 + fld(ch,4), 3*256 + 2);
            check(fld(ch,0) == 0 && fld(ch,3) == 0 && fld(ch,2) == 0, "R1", "idx/mux/rsv reset",
                  fld(ch,0) + fld(ch,3) + fld(ch,2), 0);
        end

        // R2 R3 R4: various patterns on both channels
        send_word(0, 22'h3FFFFF);
        send_word(0, 22'h000000);
        send_word(1, 22'h2AAAAA);
        send_word(1, 22'h155555);
        send_word(0, {4'b1011, 7'd45, 1'b1, 3'b010, 7'd10});

        // R5 interleave channels on the shared data line
        begin
            logic [21:0] wa, wb;
            wa = {4'b0110, 7'd100, 1'b1, 3'b101, 7'd77};
            wb = {4'b1001, 7'd3, 1'b0, 3'b111, 7'd126};
            expq[0].push_back(wa);
            send_bits(0, wa, 21, 12);
            send_word(1, wb);
            send_bits(0, wa, 11, 0);
            repeat (6) @(negedge clk);
        end

        // R8 outputs held across partial word and other-channel load
        for (int s = 0; s < 5; s++) snap[s] = fld(0, s);
        send_bits(0, 22'h1F0F0F, 21, 15);
        send_word(1, 22'h0C3C3C);
        for (int s = 0; s < 5; s++)
            check(fld(0, s) == snap[s], "R8", "held field changed", fld(0, s), snap[s]);

        // R7 refsel rise drops the partial word above
        pulse_refsel(0);
        send_word(0, 22'h2468AC);

        // R6 edge during wrong selection: error, bit rejected
        refsel[0] = 1'b1;
        repeat (8) @(negedge clk);
        send_bits(0, 22'h3FFFFF, 2, 0);
        repeat (6) @(negedge clk);
        check(err_o[0] == 1'b1, "R6", "err after edge with refsel high", int'(err_o[0]), 1);
        check(err_o[1] == 1'b0, "R5", "other channel err", int'(err_o[1]), 0);
        check(valid_o == 2'b00, "R6", "no strobe from rejected bits", int'(valid_o), 0);
        refsel[0] = 1'b0;
        repeat (8) @(negedge clk);
        send_word(0, 22'h13579B);

        // R10 sticky
        check(err_o[0] == 1'b1, "R10", "err cleared after good word", int'(err_o[0]), 1);
        send_word(1, 22'h0F00F0);
        check(err_o[1] == 1'b0, "R5", "other channel err late", int'(err_o[1]), 0);

        repeat (20) @(negedge clk);
        check(expq[0].size() == 0, "R2", "missing strobes ch0", expq[0].size(), 0);
        check(expq[1].size() == 0, "R2", "missing strobes ch1", expq[1].size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule